// File: doc/BRIEF.md
# Serial Receive Queue with Idle Timeout

This block sits between a serial-line deserializer and the register interface of a serial port. Each byte the deserializer recovers, and each line-break indication, is written into a byte-wide queue. Software, or a DMA engine, takes the bytes out through a read port that removes one byte per read. The block keeps the fill count, a full flag, a data-ready flag and a sticky error register. It compares the fill against a programmable trigger level, whose step size depends on a per-instance channel number. It also runs an idle timer, counted in whole character times, that flags data left waiting in the queue.

With the queue disabled, the block falls back to a single holding register that each new byte overwrites. Three one-cycle pulses go to the interrupt combining logic outside this block: trigger reached (a level), timeout and error. A DMA-busy level tells a DMA engine when nothing is available. The idle timer is a two-state machine. `TM_IDLE` waits for a byte. The arm transition, taken when a byte arrives with the timeout enabled, enters `TM_COUNT`. In `TM_COUNT`, a byte takes the restart transition and reloads the count. Clearing the timeout enable takes the cancel transition back to `TM_IDLE`. Once the count has reached zero, the expire transition returns to `TM_IDLE` and fires when data is present or the force bit is set.

Top module: `serial_rx_queue`

## Requirements
- R1: Out of reset the queue is disabled, both control registers read 0 except the receive control, which reads 16'h3000, and all status reads 0. In the queue control register, bit 0 enables the queue, bit 1 empties the receive queue and bit 2 is the transmit clear. Bits 1 and 2 always read back as 0.
- R2: `fifo_stat[7:0]` gives the number of stored bytes and `fifo_stat[8]` is set when all DEPTH slots are used. While the queue is full, the count field reads 0.
- R3: With the queue enabled, bytes leave in arrival order, one per cycle with `rd_pop` high, and `rd_data` shows the oldest byte combinationally. `line_stat[0]` (data ready) is 1 while any byte is stored and is 0 after the last byte is read.
- R4: The trigger level is (queue control bits [6:4] + 1) × M. M is 32 for channel 0, 8 for channels 1 and 4, 2 for channels 2 and 3, and 0 for any other channel. `trig_hit` is high when the queue is enabled and the count is at least the level.
- R5: A byte that arrives while the queue is full is dropped. It sets `err_stat[0]` (overrun) and makes `err_pulse` high in the following cycle.
- R6: A read from an empty enabled queue returns 0, changes no state and makes `err_pulse` high in the following cycle.
- R7: A break indication stores a zero byte, takes priority over a byte in the same cycle, and sets `err_stat[3]`.
- R8: `err_stat` becomes 0 in the cycle after a cycle with `err_rd` high, unless a new error arrives in that same cycle.
- R9: With receive control bit 7 set, every byte arriving in queue mode loads the timer with receive control [15:12] character times. After that many `char_tick` pulses, the next cycle expires the timer. If a byte is stored or receive control bit 11 is set, expiry sets `line_stat[3]` and pulses `tmo_pulse` one cycle later. Clearing bit 7 cancels a running count.
- R10: A cycle with `tmo_clr` high clears `line_stat[3]`, unless a new timeout fires in that same cycle.
- R11: `dma_busy` is high exactly when receive control [1:0] equals 2 and no byte is available.
- R12: With the queue disabled, each byte overwrites a single holding register and sets data ready. A read returns that byte and clears data ready, and it never raises an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fifo_ctl_we | input | 1 | Write strobe, queue control register |
| fifo_ctl_wdata | input | 8 | Queue control write data |
| fifo_ctl_q | output | 8 | Queue control readback |
| rx_ctl_we | input | 1 | Write strobe, receive control register |
| rx_ctl_wdata | input | 16 | Receive control write data |
| rx_ctl_q | output | 16 | Receive control readback |
| rx_valid | input | 1 | Deserializer byte strobe |
| rx_byte | input | 8 | Deserializer byte |
| rx_break | input | 1 | Line break indication |
| char_tick | input | 1 | One pulse per character time |
| rd_pop | input | 1 | Data read, removes one byte |
| rd_data | output | 8 | Read data |
| fifo_stat | output | 9 | Count and full flag |
| err_rd | input | 1 | Error status read, clears it |
| err_stat | output | 4 | Error status: bit 0 overrun, bit 3 break |
| tmo_clr | input | 1 | Write-one clear of the timeout flag |
| line_stat | output | 4 | Bit 0 data ready, bit 3 timeout |
| trig_hit | output | 1 | Fill reached trigger level |
| tmo_pulse | output | 1 | Timeout interrupt request pulse |
| err_pulse | output | 1 | Overrun or underrun pulse |
| dma_busy | output | 1 | DMA mode and nothing available |

## Verification
The hardest state to reach is the timer expiring with the queue empty, where the outcome depends only on the force bit. The bench stores one byte so that the timer arms, reads that byte back before any character tick, and then delivers the full tick count. It does this once with the force bit clear and once with it set. Expiry on the exact tick is checked by sampling the flag after every tick for reload values 1 to 4, and a restart is checked by storing a second byte partway through the count.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic [0:0] {
        TM_IDLE  = 1'b0,
        TM_COUNT = 1'b1
    } tm_state_t;

    function automatic int unsigned chan_mult(input int unsigned ch);
        case (ch)
            0:       chan_mult = 32;
            1, 4:    chan_mult = 8;
            2, 3:    chan_mult = 2;
            default: chan_mult = 0;
        endcase
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [7:0]       push_data,
    input  logic             pop,
    output logic [7:0]       head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;

    function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
        wrap_inc = (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else if (clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= wrap_inc(wp);
            if (pop)  rp <= wrap_inc(rp);
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= push_data;
    end

    assign head  = mem[rp];
    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);

endmodule

// File: rtl/rxq_trigger.sv
module rxq_trigger #(
    parameter int DEPTH   = 16,
    parameter int CHANNEL = 2,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int unsigned MULT = rxq_pkg::chan_mult(CHANNEL)
) (
    input  logic             enable,
    input  logic [2:0]       field,
    input  logic [CNT_W-1:0] count,
    output logic             hit
);
    generate
        if (MULT == 0) begin : g_zero_level
            assign hit = enable;
        end else begin : g_scaled_level
            logic [8:0] level;
            assign level = ({6'd0, field} + 9'd1) * 9'(MULT);
            assign hit   = enable && (9'(count) >= level);
        end
    endgenerate

endmodule

// File: rtl/rxq_timer.sv
module rxq_timer #(
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [RW-1:0] reload,
    input  logic          rearm,
    input  logic          char_tick,
    input  logic          data_present,
    input  logic          force_fire,
    output logic          fire
);
    import rxq_pkg::*;

    tm_state_t     state, state_n;
    logic [RW-1:0] rem, rem_n;

    always_comb begin
        state_n = state;
        rem_n   = rem;
        unique case (state)
            TM_IDLE: begin
                if (enable && rearm) begin
                    state_n = TM_COUNT;
                    rem_n   = reload;
                end
            end
            TM_COUNT: begin
                if (!enable)           state_n = TM_IDLE;
                else if (rearm)        rem_n   = reload;
                else if (rem == '0)    state_n = TM_IDLE;
                else if (char_tick)    rem_n   = rem - 1'b1;
            end
            default: state_n = TM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TM_IDLE;
            rem   <= '0;
        end else begin
            state <= state_n;
            rem   <= rem_n;
        end
    end

    always_comb begin
        fire = (state == TM_COUNT) && enable && !rearm && (rem == '0)
               && (data_present || force_fire);
    end

endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue #(
    parameter int DEPTH   = 16,
    parameter int CHANNEL = 2,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fifo_ctl_we,
    input  logic [7:0]  fifo_ctl_wdata,
    output logic [7:0]  fifo_ctl_q,
    input  logic        rx_ctl_we,
    input  logic [15:0] rx_ctl_wdata,
    output logic [15:0] rx_ctl_q,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    input  logic        rx_break,
    input  logic        char_tick,
    input  logic        rd_pop,
    output logic [7:0]  rd_data,
    output logic [8:0]  fifo_stat,
    input  logic        err_rd,
    output logic [3:0]  err_stat,
    input  logic        tmo_clr,
    output logic [3:0]  line_stat,
    output logic        trig_hit,
    output logic        tmo_pulse,
    output logic        err_pulse,
    output logic        dma_busy
);
    logic [7:0]       fctl;
    logic [15:0]      rctl;
    logic [7:0]       hold;
    logic             hold_v;
    logic             tmo_flag;
    logic [3:0]       err_q;
    logic             err_pulse_q, tmo_pulse_q;

    logic             fifo_en, clr, in_any, push, pop, overrun, underrun;
    logic             fire, data_present;
    logic [7:0]       in_byte, head;
    logic [CNT_W-1:0] count;
    logic             full, empty;

    assign fifo_en  = fctl[0];
    assign clr      = fifo_ctl_we && fifo_ctl_wdata[1];
    assign in_any   = rx_valid || rx_break;
    assign in_byte  = rx_break ? 8'h00 : rx_byte;
    assign push     = fifo_en && in_any && !full && !clr;
    assign overrun  = fifo_en && in_any && full && !clr;
    assign pop      = fifo_en && rd_pop && !empty && !clr;
    assign underrun = fifo_en && rd_pop && empty;

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .push      (push),
        .push_data (in_byte),
        .pop       (pop),
        .head      (head),
        .count     (count),
        .full      (full),
        .empty     (empty)
    );

    rxq_trigger #(.DEPTH(DEPTH), .CHANNEL(CHANNEL)) u_trig (
        .enable (fifo_en),
        .field  (fctl[6:4]),
        .count  (count),
        .hit    (trig_hit)
    );

    assign data_present = fifo_en ? !empty : hold_v;

    rxq_timer #(.RW(4)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (rctl[7]),
        .reload       (rctl[15:12]),
        .rearm        (fifo_en && in_any),
        .char_tick    (char_tick),
        .data_present (data_present),
        .force_fire   (rctl[11]),
        .fire         (fire)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fctl        <= 8'h00;
            rctl        <= 16'h3000;
            hold        <= 8'h00;
            hold_v      <= 1'b0;
            tmo_flag    <= 1'b0;
            err_q       <= 4'h0;
            err_pulse_q <= 1'b0;
            tmo_pulse_q <= 1'b0;
        end else begin
            if (fifo_ctl_we) fctl <= {fifo_ctl_wdata[7:3], 2'b00, fifo_ctl_wdata[0]};
            if (rx_ctl_we)   rctl <= rx_ctl_wdata;
            if (!fifo_en && in_any) begin
                hold   <= in_byte;
                hold_v <= 1'b1;
            end else if (!fifo_en && rd_pop) begin
                hold_v <= 1'b0;
            end
            tmo_flag    <= (tmo_flag && !tmo_clr) || fire;
            err_q       <= (err_rd ? 4'h0 : err_q) | {rx_break, 2'b00, overrun};
            err_pulse_q <= overrun || underrun;
            tmo_pulse_q <= fire;
        end
    end

    assign fifo_ctl_q = fctl;
    assign rx_ctl_q   = rctl;
    assign rd_data    = fifo_en ? (empty ? 8'h00 : head) : hold;
    assign fifo_stat  = {full, full ? 8'h00 : 8'(count)};
    assign err_stat   = err_q;
    assign line_stat  = {tmo_flag, 2'b00, data_present};
    assign tmo_pulse  = tmo_pulse_q;
    assign err_pulse  = err_pulse_q;
    assign dma_busy   = (rctl[1:0] == 2'd2) && !data_present;

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        fifo_ctl_we,
    input logic [7:0]  fifo_ctl_wdata,
    input logic [7:0]  fifo_ctl_q,
    input logic [15:0] rx_ctl_q,
    input logic        rx_valid,
    input logic        rx_break,
    input logic        rd_pop,
    input logic [7:0]  rd_data,
    input logic [8:0]  fifo_stat,
    input logic        err_rd,
    input logic [3:0]  err_stat,
    input logic [3:0]  line_stat,
    input logic        tmo_pulse,
    input logic        err_pulse,
    input logic        dma_busy
);
    // R1: a queue clear empties the queue
    p_clear_empties_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_ctl_we && fifo_ctl_wdata[1]) |=> (fifo_stat == 9'd0));

    // R1: clear bits never read back
    p_clear_bits_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_ctl_q[2:1] == 2'b00);

    // R2: full flag forces the count field to zero
    p_full_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_stat[8] |-> (fifo_stat[7:0] == 8'd0));

    // R6: empty read yields zero and an error pulse
    p_underrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_ctl_q[0] && rd_pop && fifo_stat == 9'd0 && !fifo_ctl_we)
        |-> (rd_data == 8'h00) ##1 err_pulse);

    // R7: break sets the break status bit
    p_break_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_break |=> err_stat[3]);

    // R8: read clears error status when nothing new arrives
    p_err_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_rd && !rx_break && !rx_valid) |=> (err_stat == 4'h0));

    // R9: a timeout pulse always comes with the timeout flag
    p_tmo_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_pulse |-> line_stat[3]);

    // R11: DMA busy only when nothing is ready
    p_dma_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dma_busy |-> (!line_stat[0] && rx_ctl_q[1:0] == 2'd2));

endmodule

bind serial_rx_queue rxq_checker u_rxq_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .fifo_ctl_we    (fifo_ctl_we),
    .fifo_ctl_wdata (fifo_ctl_wdata),
    .fifo_ctl_q     (fifo_ctl_q),
    .rx_ctl_q       (rx_ctl_q),
    .rx_valid       (rx_valid),
    .rx_break       (rx_break),
    .rd_pop         (rd_pop),
    .rd_data        (rd_data),
    .fifo_stat      (fifo_stat),
    .err_rd         (err_rd),
    .err_stat       (err_stat),
    .line_stat      (line_stat),
    .tmo_pulse      (tmo_pulse),
    .err_pulse      (err_pulse),
    .dma_busy       (dma_busy)
);

// File: tb/serial_rx_queue_bench.sv
`timescale 1ns/1ps
module serial_rx_queue_bench;
    localparam int DEPTH = 16;
    localparam int MULT  = 2;   // channel 2

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_ctl_we = 1'b0;
    logic [7:0]  fifo_ctl_wdata = '0;
    logic [7:0]  fifo_ctl_q;
    logic        rx_ctl_we = 1'b0;
    logic [15:0] rx_ctl_wdata = '0;
    logic [15:0] rx_ctl_q;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_break = 1'b0;
    logic        char_tick = 1'b0;
    logic        rd_pop = 1'b0;
    logic [7:0]  rd_data;
    logic [8:0]  fifo_stat;
    logic        err_rd = 1'b0;
    logic [3:0]  err_stat;
    logic        tmo_clr = 1'b0;
    logic [3:0]  line_stat;
    logic        trig_hit, tmo_pulse, err_pulse, dma_busy;

    int checks = 0;
    int errors = 0;
    logic [7:0] got;

    always #4 clk = ~clk;

    serial_rx_queue #(.DEPTH(DEPTH), .CHANNEL(2)) u_serial_rx_queue (.*);

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic wr_fctl(input logic [7:0] v);
        fifo_ctl_we = 1'b1; fifo_ctl_wdata = v; cyc(); fifo_ctl_we = 1'b0;
    endtask

    task automatic wr_rctl(input logic [15:0] v);
        rx_ctl_we = 1'b1; rx_ctl_wdata = v; cyc(); rx_ctl_we = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        rx_valid = 1'b1; rx_byte = b; cyc(); rx_valid = 1'b0;
    endtask

    task automatic brk();
        rx_break = 1'b1; cyc(); rx_break = 1'b0;
    endtask

    task automatic pop(output logic [7:0] d);
        rd_pop = 1'b1; #1 d = rd_data; @(negedge clk) ; rd_pop = 1'b0;
    endtask

    task automatic tick();
        char_tick = 1'b1; cyc(); char_tick = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 fifo_stat", fifo_stat, 0);
        check("R1 line_stat", line_stat, 0);
        check("R1 err_stat", err_stat, 0);
        check("R1 fifo_ctl", fifo_ctl_q, 0);
        check("R1 rx_ctl", rx_ctl_q, 16'h3000);
        check("R1 trig", trig_hit, 0);
        check("R11 dma reset", dma_busy, 0);

        // R1: clear bits self-clear
        wr_fctl(8'h07);
        check("R1 clear bits", fifo_ctl_q, 8'h01);

        // R2 R3: fill to every level, drain in order
        for (int n = 1; n <= DEPTH; n++) begin
            wr_fctl(8'h03);
            for (int i = 0; i < n; i++) push(8'((n * 7 + i) & 255));
            check("R2 count", fifo_stat, (n == DEPTH) ? 9'h100 : n);
            for (int i = 0; i < n; i++) begin
                pop(got);
                check("R3 order", got, (n * 7 + i) & 255);
                check("R3 ready", line_stat[0], (i < n - 1) ? 1 : 0);
            end
        end

        // R4: trigger sweep
        for (int f = 0; f < 8; f++) begin
            wr_fctl(8'(f << 4) | 8'h03);
            for (int k = 0; k <= DEPTH; k++) begin
                check("R4 trig", trig_hit, (k >= (f + 1) * MULT) ? 1 : 0);
                if (k < DEPTH) push(8'(k));
            end
        end
        wr_fctl(8'h00);
        check("R4 trig disabled", trig_hit, 0);

        // R5: overrun
        wr_fctl(8'h03);
        for (int i = 0; i < DEPTH; i++) push(8'(i + 1));
        push(8'hAA);
        check("R5 err_pulse", err_pulse, 1);
        check("R5 overrun bit", err_stat[0], 1);
        check("R5 still full", fifo_stat, 9'h100);
        for (int i = 0; i < DEPTH; i++) begin
            pop(got);
            check("R5 kept data", got, i + 1);
        end

        // R6: underrun
        cyc();
        check("R6 no pulse idle", err_pulse, 0);
        pop(got);
        check("R6 data zero", got, 0);
        check("R6 err_pulse", err_pulse, 1);
        check("R6 count", fifo_stat, 0);

        // R8: read clear
        err_rd = 1'b1; cyc(); err_rd = 1'b0;
        check("R8 cleared", err_stat, 0);

        // R7: break
        push(8'h55);
        brk();
        check("R7 count", fifo_stat, 2);
        check("R7 break bit", err_stat, 4'h8);
        pop(got); check("R7 first", got, 8'h55);
        pop(got); check("R7 zero byte", got, 0);
        err_rd = 1'b1; cyc(); err_rd = 1'b0;
        check("R8 cleared break", err_stat, 0);

        // R1: clear empties
        push(8'h01); push(8'h02); push(8'h03);
        wr_fctl(8'h03);
        check("R1 cleared", fifo_stat, 0);
        check("R3 ready after clear", line_stat[0], 0);

        // R9 R10: exact expiry
        for (int r = 1; r <= 4; r++) begin
            wr_rctl(16'(r << 12) | 16'h0080);
            wr_fctl(8'h03);
            push(8'h9C);
            for (int t = 1; t <= r; t++) begin
                tick();
                check("R9 not yet", line_stat[3], 0);
            end
            cyc();
            check("R9 flag", line_stat[3], 1);
            check("R9 pulse", tmo_pulse, 1);
            cyc();
            check("R9 pulse one cycle", tmo_pulse, 0);
            tmo_clr = 1'b1; cyc(); tmo_clr = 1'b0;
            check("R10 cleared", line_stat[3], 0);
        end

        // R9: restart on new byte
        wr_rctl(16'h3080);
        wr_fctl(8'h03);
        push(8'h01); tick(); tick();
        push(8'h02); tick(); tick();
        cyc();
        check("R9 restart", line_stat[3], 0);
        tick(); cyc();
        check("R9 restart expiry", line_stat[3], 1);
        tmo_clr = 1'b1; cyc(); tmo_clr = 1'b0;

        // R9: empty queue without and with force bit
        wr_fctl(8'h03);
        push(8'h11); pop(got);
        tick(); tick(); tick(); cyc(); cyc();
        check("R9 empty no fire", line_stat[3], 0);
        wr_rctl(16'h3880);
        push(8'h12); pop(got);
        tick(); tick(); tick(); cyc();
        check("R9 forced fire", line_stat[3], 1);
        tmo_clr = 1'b1; cyc(); tmo_clr = 1'b0;

        // R9: cancel
        wr_rctl(16'h3080);
        push(8'h13);
        wr_rctl(16'h3000);
        tick(); tick(); tick(); tick(); cyc(); cyc();
        check("R9 cancelled", line_stat[3], 0);

        // R11: DMA busy
        wr_fctl(8'h03);
        wr_rctl(16'h0002);
        check("R11 busy empty", dma_busy, 1);
        push(8'h21);
        check("R11 not busy data", dma_busy, 0);
        wr_rctl(16'h0001);
        wr_fctl(8'h03);
        check("R11 other mode", dma_busy, 0);

        // R12: holding register mode
        wr_fctl(8'h00);
        push(8'h11); push(8'h22);
        check("R12 ready", line_stat[0], 1);
        pop(got);
        check("R12 data", got, 8'h22);
        check("R12 no err", err_pulse, 0);
        check("R12 ready clear", line_stat[0], 0);
        pop(got);
        check("R12 empty read no err", err_pulse, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule